// File: doc/BRIEF.md
# Host Bus Power-Mode Controller

This block governs the operating mode of a peripheral that a host reaches over an asynchronous SRAM-style bus with chip enable, output enable, write enable, a 13-bit address and a 16-bit data path. It keeps one of three modes: Normal, Reset and Deep Power-Down. The mode decides which host writes are passed on to the peripheral's register file, what host reads return, and whether the block drives the data pins at all.

The host changes mode with a two-step handshake. It writes a mode value to a control word, then writes the bitwise complement of that value to a confirmation word. Deep Power-Down turns off a regulator-enable and an input-buffer-enable output. To wake the block, the host reads any address three times and then reads once more. The block then goes back to the mode it held before it slept. A hardware reset input pulls the block out of any mode. It holds a busy output high until the block is ready again in Reset mode. Bus strobes are synchronised to the block clock, and each bus cycle is seen as an edge of the synchronised strobe.

Top module: `hbpm_ctrl`

## Requirements
- R1: After the synchronous reset, `mode_o` is 2'b00 (Reset), `busy_o` is low, `regulator_en_o` and `inbuf_en_o` are high, and `bus_drive_o` is low. Mode codes: 2'b00 Reset, 2'b01 Normal, 2'b10 Deep Power-Down.
- R2: In Normal mode, a read of an ordinary address drives `reg_rd_data_i` onto `bus_rdata_o` with `bus_drive_o` high. A read of the control word (address CTRL_ADDR = 13'h1FF0) or the confirmation word (CONF_ADDR = 13'h1FF1) returns the mode code in bits [1:0] and zero in the other bits.
- R3: In Normal mode, each write to an address other than the two control words produces exactly one `fwd_wr_o` pulse, carrying that address and data.
- R4: In Reset mode, writes to ordinary addresses never raise `fwd_wr_o`. The control and confirmation words still work, so writing 16'h0001 then 16'h00FE moves the block to Normal.
- R5: In Reset mode, every read drives the bus with 16'h0000.
- R6: A mode change needs the control write to be followed directly by a confirmation write whose low byte is the bitwise complement of the control low byte. The control value must have bits [7:2] at zero and a legal mode code. With a mismatched complement, an intervening write, or mode code 2'b11, the mode stays the same.
- R7: Confirming mode 2'b10 enters Deep Power-Down. `regulator_en_o` and `inbuf_en_o` go low, reads leave `bus_drive_o` low, and writes raise no `fwd_wr_o` and change no mode.
- R8: In Deep Power-Down, `regulator_en_o` rises when the first read cycle starts. `inbuf_en_o` rises only after the third read cycle completes, and the mode is still Deep Power-Down at that point.
- R9: The fourth completed read returns the block to the mode it held before Deep Power-Down (Normal or Reset), with both enables high. The mode code read back afterwards matches the earlier one.
- R10: While `hard_reset_i` is high, the block forces Reset mode, sets `busy_o` and turns both enables on. This also applies in Deep Power-Down. `busy_o` stays high for 16 clock cycles after the synchronised release, then falls, and the mode is Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_reset_i | input | 1 | Asynchronous hardware reset request, active high |
| bus_ce_n_i | input | 1 | Host chip enable, active low |
| bus_oe_n_i | input | 1 | Host output enable, active low |
| bus_we_n_i | input | 1 | Host write enable, active low |
| bus_addr_i | input | 13 | Host address |
| bus_wdata_i | input | 16 | Host write data |
| bus_rdata_o | output | 16 | Read data toward the data pins |
| bus_drive_o | output | 1 | Output enable for the data pins |
| reg_rd_data_i | input | 16 | Read data from the register file |
| fwd_wr_o | output | 1 | One-cycle write strobe to the register file |
| fwd_addr_o | output | 13 | Forwarded write address |
| fwd_data_o | output | 16 | Forwarded write data |
| regulator_en_o | output | 1 | Enable for the internal regulators |
| inbuf_en_o | output | 1 | Enable for the input buffers |
| busy_o | output | 1 | High while recovering from hardware reset |
| mode_o | output | 2 | Current mode code |

## Verification
The hardest state to reach is the middle of the wake-up sequence. There the regulator is already on, the buffers are still off, and the block has not left Deep Power-Down. The bench reaches it only through the handshake and then a counted series of reads. It checks the enables between every read, and it tests the fourth read both from Normal and from Reset so that the return path to each earlier mode is covered. A hardware reset is also applied while the block is in Deep Power-Down, and the busy window is measured against the release edge.

// File: rtl/hbpm_pkg.sv
package hbpm_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_SLEEP  = 2'b10
    } mode_e;

    // events decoded from the synchronised bus strobes
    typedef struct packed {
        logic rd_lvl;
        logic rd_start;
        logic rd_end;
        logic wr_start;
        logic hard_rst;
    } bus_evt_t;

    function automatic logic confirm_ok(input logic [7:0] ctrl, input logic [7:0] conf);
        return conf == ~ctrl;
    endfunction

    function automatic logic code_legal(input logic [7:0] ctrl);
        return (ctrl[7:2] == 6'd0) && (ctrl[1:0] != 2'b11);
    endfunction

endpackage

// File: rtl/hbpm_bus_sync.sv
module hbpm_bus_sync
    import hbpm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     we_n,
    input  logic     hard_rst,
    output bus_evt_t evt
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] IDLE = 4'b0111; // {hard, we, oe, ce}

    logic [NSIG-1:0] pipe [SYNC_STAGES];
    logic            rd_q, wr_q;
    logic            rd_now, wr_now;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= IDLE;
                else if (s == 0) pipe[s] <= {hard_rst, we_n, oe_n, ce_n};
                else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign rd_now = ~pipe[SYNC_STAGES-1][0] & ~pipe[SYNC_STAGES-1][1];
    assign wr_now = ~pipe[SYNC_STAGES-1][0] & ~pipe[SYNC_STAGES-1][2];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_now;
            wr_q <= wr_now;
        end
    end

    always_comb begin
        evt.rd_lvl   = rd_now;
        evt.rd_start = rd_now & ~rd_q;
        evt.rd_end   = ~rd_now & rd_q;
        evt.wr_start = wr_now & ~wr_q;
        evt.hard_rst = pipe[SYNC_STAGES-1][3];
    end
endmodule

// File: rtl/hbpm_mode_fsm.sv
module hbpm_mode_fsm
    import hbpm_pkg::*;
#(
    parameter int              ADDR_W      = 13,
    parameter int              DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF0,
    parameter logic [ADDR_W-1:0] CONF_ADDR = 13'h1FF1,
    parameter int              WAKE_READS  = 3,
    parameter int              BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              rd_end,
    input  logic              wr_start,
    input  logic              hard_rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_e             mode,
    output logic              busy,
    output logic              reg_on,
    output logic              buf_on,
    output logic              fwd_wr,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [DATA_W-1:0] fwd_data
);
    localparam int WAKE_W = $clog2(WAKE_READS + 1);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(WAKE_READS);
    localparam logic [BUSY_W-1:0] BUSY_LAST = BUSY_W'(BUSY_CYCLES - 1);

    mode_e             prev_mode;
    logic [7:0]        pend;
    logic              pend_vld;
    logic [WAKE_W-1:0] wake_cnt;
    logic [BUSY_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_RESET;
            prev_mode <= MODE_RESET;
            pend      <= '0;
            pend_vld  <= 1'b0;
            wake_cnt  <= '0;
            busy_cnt  <= '0;
            busy      <= 1'b0;
            reg_on    <= 1'b1;
            buf_on    <= 1'b1;
            fwd_wr    <= 1'b0;
            fwd_addr  <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_wr <= 1'b0;
            if (hard_rst) begin
                mode     <= MODE_RESET;
                busy     <= 1'b1;
                busy_cnt <= '0;
                reg_on   <= 1'b1;
                buf_on   <= 1'b1;
                wake_cnt <= '0;
                pend_vld <= 1'b0;
            end else if (busy) begin
                if (busy_cnt == BUSY_LAST) busy <= 1'b0;
                else busy_cnt <= busy_cnt + 1'b1;
            end else if (mode == MODE_SLEEP) begin
                if (rd_start) reg_on <= 1'b1;
                if (rd_end) begin
                    if (wake_cnt == WAKE_LAST) begin
                        mode     <= prev_mode;
                        wake_cnt <= '0;
                    end else begin
                        wake_cnt <= wake_cnt + 1'b1;
                        if (wake_cnt == WAKE_LAST - 1'b1) buf_on <= 1'b1;
                    end
                end
            end else if (wr_start) begin
                if (wr_addr == CTRL_ADDR) begin
                    pend     <= wr_data[7:0];
                    pend_vld <= 1'b1;
                end else if (wr_addr == CONF_ADDR) begin
                    pend_vld <= 1'b0;
                    if (pend_vld && confirm_ok(pend, wr_data[7:0]) && code_legal(pend)) begin
                        if (pend[1:0] == MODE_SLEEP) begin
                            prev_mode <= mode;
                            mode      <= MODE_SLEEP;
                            reg_on    <= 1'b0;
                            buf_on    <= 1'b0;
                            wake_cnt  <= '0;
                        end else begin
                            mode <= mode_e'(pend[1:0]);
                        end
                    end
                end else begin
                    pend_vld <= 1'b0;
                    if (mode == MODE_NORMAL) begin
                        fwd_wr   <= 1'b1;
                        fwd_addr <= wr_addr;
                        fwd_data <= wr_data;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hbpm_read_mux.sv
module hbpm_read_mux
    import hbpm_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF0,
    parameter logic [ADDR_W-1:0] CONF_ADDR = 13'h1FF1
) (
    input  mode_e             mode,
    input  logic              busy,
    input  logic              rd_lvl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] reg_data,
    output logic              drive,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        drive = rd_lvl && !busy && (mode != MODE_SLEEP);
        rdata = '0;
        if (drive && mode == MODE_NORMAL) begin
            if (addr == CTRL_ADDR || addr == CONF_ADDR) rdata = DATA_W'(mode);
            else rdata = reg_data;
        end
    end
endmodule

// File: rtl/hbpm_ctrl.sv
module hbpm_ctrl
    import hbpm_pkg::*;
#(
    parameter int                ADDR_W      = 13,
    parameter int                DATA_W      = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 13'h1FF0,
    parameter logic [ADDR_W-1:0] CONF_ADDR   = 13'h1FF1,
    parameter int                SYNC_STAGES = 2,
    parameter int                WAKE_READS  = 3,
    parameter int                BUSY_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_reset_i,
    input  logic              bus_ce_n_i,
    input  logic              bus_oe_n_i,
    input  logic              bus_we_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_drive_o,
    input  logic [DATA_W-1:0] reg_rd_data_i,
    output logic              fwd_wr_o,
    output logic [ADDR_W-1:0] fwd_addr_o,
    output logic [DATA_W-1:0] fwd_data_o,
    output logic              regulator_en_o,
    output logic              inbuf_en_o,
    output logic              busy_o,
    output logic [1:0]        mode_o
);
    bus_evt_t evt;
    mode_e    mode;

    hbpm_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .ce_n(bus_ce_n_i), .oe_n(bus_oe_n_i), .we_n(bus_we_n_i),
        .hard_rst(hard_reset_i), .evt(evt)
    );

    hbpm_mode_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .CONF_ADDR(CONF_ADDR),
        .WAKE_READS(WAKE_READS), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .rd_start(evt.rd_start), .rd_end(evt.rd_end), .wr_start(evt.wr_start),
        .hard_rst(evt.hard_rst), .wr_addr(bus_addr_i), .wr_data(bus_wdata_i),
        .mode(mode), .busy(busy_o), .reg_on(regulator_en_o), .buf_on(inbuf_en_o),
        .fwd_wr(fwd_wr_o), .fwd_addr(fwd_addr_o), .fwd_data(fwd_data_o)
    );

    hbpm_read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .CONF_ADDR(CONF_ADDR)
    ) u_rmux (
        .mode(mode), .busy(busy_o), .rd_lvl(evt.rd_lvl), .addr(bus_addr_i),
        .reg_data(reg_rd_data_i), .drive(bus_drive_o), .rdata(bus_rdata_o)
    );

    assign mode_o = mode;
endmodule

// File: rtl/hbpm_ctrl_chk.sv
module hbpm_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_o,
    input logic              busy_o,
    input logic              bus_drive_o,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              fwd_wr_o,
    input logic              regulator_en_o,
    input logic              inbuf_en_o
);
    assert_sleep_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> !bus_drive_o);

    assert_sleep_no_fwd_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> !fwd_wr_o);

    assert_reset_no_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00) |-> !fwd_wr_o);

    assert_reset_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b00 && bus_drive_o) |-> (bus_rdata_o == '0));

    assert_buf_after_reg_R8: assert property (@(posedge clk) disable iff (rst)
        !regulator_en_o |-> !inbuf_en_o);

    assert_wake_enables_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 2'b10 && mode_o != 2'b10) |-> (regulator_en_o && inbuf_en_o));

    assert_busy_in_reset_R10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (mode_o == 2'b00 && !bus_drive_o));
endmodule

bind hbpm_ctrl hbpm_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .mode_o(mode_o), .busy_o(busy_o),
    .bus_drive_o(bus_drive_o), .bus_rdata_o(bus_rdata_o), .fwd_wr_o(fwd_wr_o),
    .regulator_en_o(regulator_en_o), .inbuf_en_o(inbuf_en_o)
);

// File: tb/hbpm_ctrl_bench.sv
module hbpm_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [12:0] CTRL = 13'h1FF0;
    localparam logic [12:0] CONF = 13'h1FF1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hard_reset = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, fwd_data, reg_rd;
    logic [12:0] fwd_addr;
    logic        drive, fwd_wr, reg_en, buf_en, busy;
    logic [1:0]  mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [28:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign reg_rd = {3'b000, addr} ^ 16'hA000;

    hbpm_ctrl u_hbpm_ctrl (
        .clk(clk), .rst(rst), .hard_reset_i(hard_reset),
        .bus_ce_n_i(ce_n), .bus_oe_n_i(oe_n), .bus_we_n_i(we_n),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_drive_o(drive),
        .reg_rd_data_i(reg_rd), .fwd_wr_o(fwd_wr), .fwd_addr_o(fwd_addr), .fwd_data_o(fwd_data),
        .regulator_en_o(reg_en), .inbuf_en_o(buf_en), .busy_o(busy), .mode_o(mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: every forwarded write must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && fwd_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3/R4/R7 unexpected write actual %h expected none", {fwd_addr, fwd_data});
            end else begin
                logic [28:0] e;
                e = exp_q.pop_front();
                if ({fwd_addr, fwd_data} !== e) begin
                    errors++;
                    $display("FAIL R3 forwarded write actual %h expected %h", {fwd_addr, fwd_data}, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [12:0] a, input logic [15:0] d, input bit expect_fwd);
        if (expect_fwd) exp_q.push_back({a, d});
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_read(input logic [12:0] a, input logic exp_drv,
                            input logic [15:0] exp_d, input string req);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check(req, {31'd0, drive}, {31'd0, exp_drv});
        if (exp_drv) check(req, {16'd0, rdata}, {16'd0, exp_d});
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        bus_write(CTRL, {14'd0, m}, 0);
        bus_write(CONF, {8'd0, ~{6'd0, m}}, 0);
    endtask

    task automatic wake_sequence(input logic [1:0] back);
        bus_read(13'h0777, 1'b0, 16'h0, "R7 sleep read undriven");
        check("R8 regulator on after first read", {31'd0, reg_en}, 32'd1);
        check("R8 buffers off after first read", {31'd0, buf_en}, 32'd0);
        bus_read(13'h0777, 1'b0, 16'h0, "R8 second read undriven");
        check("R8 buffers off after second read", {31'd0, buf_en}, 32'd0);
        bus_read(13'h1FFF, 1'b0, 16'h0, "R8 third read undriven");
        check("R8 buffers on after third read", {31'd0, buf_en}, 32'd1);
        check("R8 still asleep after third read", {30'd0, mode}, 32'd2);
        bus_read(13'h1FFF, 1'b0, 16'h0, "R9 fourth read undriven");
        check("R9 mode restored", {30'd0, mode}, {30'd0, back});
        check("R9 regulator on", {31'd0, reg_en}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", {30'd0, mode}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 regulator", {31'd0, reg_en}, 32'd1);
        check("R1 buffers", {31'd0, buf_en}, 32'd1);
        check("R1 drive", {31'd0, drive}, 32'd0);

        // R4/R5 Reset mode filtering
        bus_write(13'h0100, 16'h1111, 0);
        bus_read(13'h0100, 1'b1, 16'h0000, "R5 reset read zero");
        bus_read(CTRL, 1'b1, 16'h0000, "R5 reset control read zero");

        // R6 broken handshakes
        bus_write(CTRL, 16'h0001, 0);
        bus_write(13'h0200, 16'h2222, 0);
        bus_write(CONF, 16'h00FE, 0);
        check("R6 intervening write", {30'd0, mode}, 32'd0);
        bus_write(CTRL, 16'h0001, 0);
        bus_write(CONF, 16'h00FF, 0);
        check("R6 bad complement", {30'd0, mode}, 32'd0);
        bus_write(CTRL, 16'h0003, 0);
        bus_write(CONF, 16'h00FC, 0);
        check("R6 illegal code", {30'd0, mode}, 32'd0);

        // R4 control words still work in Reset mode
        set_mode(2'b01);
        check("R4 reset to normal", {30'd0, mode}, 32'd1);

        // R3/R2 Normal mode
        bus_write(13'h0123, 16'hBEEF, 1);
        bus_write(13'h1ABC, 16'h1234, 1);
        bus_read(13'h0123, 1'b1, 16'hA123, "R2 normal read");
        bus_read(13'h0000, 1'b1, 16'hA000, "R2 normal read low");
        bus_read(CTRL, 1'b1, 16'h0001, "R2 control readback");

        // R7 sleep from Normal
        set_mode(2'b10);
        check("R7 mode sleep", {30'd0, mode}, 32'd2);
        check("R7 regulator off", {31'd0, reg_en}, 32'd0);
        check("R7 buffers off", {31'd0, buf_en}, 32'd0);
        bus_write(13'h0055, 16'h5555, 0);
        bus_write(CTRL, 16'h0001, 0);
        check("R7 write ignored", {30'd0, mode}, 32'd2);
        check("R7 regulator still off", {31'd0, reg_en}, 32'd0);
        wake_sequence(2'b01);
        bus_read(CTRL, 1'b1, 16'h0001, "R9 mode readback");

        // R9 sleep from Reset
        set_mode(2'b00);
        check("R9 normal to reset", {30'd0, mode}, 32'd0);
        set_mode(2'b10);
        check("R9 reset to sleep", {30'd0, mode}, 32'd2);
        wake_sequence(2'b00);

        // R10 hardware reset out of sleep
        set_mode(2'b10);
        check("R10 asleep before reset", {30'd0, mode}, 32'd2);
        hard_reset = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 busy during reset", {31'd0, busy}, 32'd1);
        check("R10 mode reset", {30'd0, mode}, 32'd0);
        check("R10 regulator on", {31'd0, reg_en}, 32'd1);
        check("R10 buffers on", {31'd0, buf_en}, 32'd1);
        hard_reset = 1'b0;
        repeat (16) @(negedge clk);
        check("R10 busy held", {31'd0, busy}, 32'd1);
        repeat (3) @(negedge clk);
        check("R10 busy released", {31'd0, busy}, 32'd0);
        check("R10 mode after busy", {30'd0, mode}, 32'd0);
        set_mode(2'b01);
        bus_write(13'h0042, 16'h4242, 1);
        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule